// File: doc/BRIEF.md
# Ethernet Receive Frame Parser

This block sits behind a double-data-rate receive front end that already delivers one byte per 125 MHz cycle. Alongside each byte come a data-valid flag and a receive-error flag. The front end builds each byte from the low nibble sampled on the rising edge and the high nibble sampled on the falling edge. Data-valid is the rising-edge sample of the control line. The error flag is the XOR of the rising-edge and falling-edge control samples.

The parser hunts for the preamble and the start-of-frame delimiter. It then forwards every frame byte from the destination address through the end of the payload on an AXI4-Stream master, one beat per cycle. The four trailing checksum bytes are held back and never forwarded. The checksum is verified over the whole frame. The final forwarded beat carries tlast, and tuser on that beat marks the frame as bad for a checksum mismatch, a receive error or a runt. There is no tready, because the receive link cannot be stalled.

Top module: `eth_rx_parser`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, m_tvalid, m_tlast and m_tuser are 0.
- R2: A frame starts only after at least seven consecutive 0x55 bytes are followed by 0xD5, all with data-valid high. A 0xD5 after fewer than seven 0x55 bytes causes the rest of that data-valid burst to be ignored. Any other byte restarts the preamble count.
- R3: The byte that follows 0xD5 is the first one forwarded. Bytes leave in arrival order. Byte k of a frame appears on m_tdata in the cycle after byte k+5 was sampled. No preamble or delimiter byte is ever forwarded.
- R4: The last four bytes of a frame (the checksum) are not forwarded. tlast is set on the byte just before them, in the cycle after the first data-valid-low cycle. tlast and tuser are 0 on every other beat.
- R5: A CRC-32 (reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF) runs over all bytes after 0xD5, checksum included. tuser is set on the tlast beat unless the register ends at 0xDEBB20E3.
- R6: A receive error seen with data-valid high at any point within a frame sets tuser on that frame's tlast beat.
- R7: A frame with fewer than 64 bytes after 0xD5, checksum included, is a runt and gets tuser on its tlast beat. A frame of 64 bytes is not a runt.
- R8: A frame with fewer than five bytes after 0xD5 produces no beats at all. A frame of exactly five bytes produces one beat, with tlast set.
- R9: A single data-valid-low cycle between two frames is enough for both to be parsed in full.
- R10: A receive error during the preamble hunt causes the rest of that data-valid burst to be ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Received byte from the DDR front end |
| rx_dv | input | 1 | Data-valid (rising-edge control sample) |
| rx_er | input | 1 | Receive error (XOR of both control samples) |
| m_tdata | output | 8 | Stream data byte |
| m_tvalid | output | 1 | Stream beat valid |
| m_tlast | output | 1 | Last payload byte of the frame |
| m_tuser | output | 1 | Frame bad (CRC, receive error or runt), valid with tlast |

## Verification
The assertions check the framing rules on every cycle. A frame only begins right after a 0xD5 byte. Beats only come out of an active frame. tlast always comes with a valid beat and is followed by an idle cycle. tuser never appears without tlast. Mid-frame beats only follow a cycle with data-valid high. Only the bench's reference model can show that the bytes come out with the right content, latency and ordering. It also checks that the CRC, runt and error verdicts are right for a given frame, and that short preambles, error-hit preambles and tiny frames drop the right bytes.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB20E3;
    localparam logic [7:0]  PRE_BYTE      = 8'h55;
    localparam logic [7:0]  SFD_BYTE      = 8'hD5;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_DATA = 2'd1,
        ST_DROP = 2'd2
    } rx_state_e;

    // one byte through the LSB-first CRC-32 register
    function automatic logic [31:0] crc32_step(input logic [31:0] crc, input logic [7:0] b);
        logic [31:0] c;
        c = crc ^ {24'd0, b};
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/eth_rx_crc32.sv
module eth_rx_crc32
    import eth_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       advance_i,
    input  logic [7:0] byte_i,
    output logic       good_o
);

    typedef struct packed {
        logic [31:0] crc;
    } crc_state_t;

    crc_state_t crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clear_i) begin
            crc_d.crc = CRC_SEED;
        end else if (advance_i) begin
            crc_d.crc = crc32_step(crc_q.crc, byte_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q.crc <= CRC_SEED;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign good_o = (crc_q.crc == CRC_RESIDUE);

endmodule

// File: rtl/eth_rx_fcs_hold.sv
module eth_rx_fcs_hold #(
    parameter int W     = 8,
    parameter int DEPTH = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush_i,
    input  logic         push_i,
    input  logic [W-1:0] byte_i,
    output logic         full_o,
    output logic [W-1:0] oldest_o
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FILL_MAX = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slot;
        logic [CW-1:0]           fill;
    } hold_state_t;

    hold_state_t hold_d, hold_q;
    logic [W-1:0] shifted [DEPTH];

    assign shifted[0] = byte_i;
    generate
        for (genvar i = 1; i < DEPTH; i++) begin : g_stage
            assign shifted[i] = hold_q.slot[i-1];
        end
    endgenerate

    always_comb begin
        hold_d = hold_q;
        if (flush_i) begin
            hold_d.fill = '0;
        end else if (push_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                hold_d.slot[i] = shifted[i];
            end
            if (hold_q.fill != FILL_MAX) begin
                hold_d.fill = hold_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign full_o   = (hold_q.fill == FILL_MAX);
    assign oldest_o = hold_q.slot[DEPTH-1];

endmodule

// File: rtl/eth_rx_parser.sv
module eth_rx_parser
    import eth_rx_pkg::*;
#(
    parameter int PREAMBLE_LEN = 7,
    parameter int MIN_FRAME    = 64,
    parameter int FCS_BYTES    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] rx_data,
    input  logic       rx_dv,
    input  logic       rx_er,
    output logic [7:0] m_tdata,
    output logic       m_tvalid,
    output logic       m_tlast,
    output logic       m_tuser
);

    localparam int HOLD_DEPTH = FCS_BYTES + 1;
    localparam int PCW = $clog2(PREAMBLE_LEN + 1);
    localparam int LCW = $clog2(MIN_FRAME + 1);
    localparam logic [PCW-1:0] PRE_MAX = PCW'(PREAMBLE_LEN);
    localparam logic [LCW-1:0] LEN_MAX = LCW'(MIN_FRAME);

    typedef struct packed {
        rx_state_e      state;
        logic [PCW-1:0] pre_cnt;
        logic [LCW-1:0] len_cnt;
        logic           err;
        logic           out_valid;
        logic [7:0]     out_data;
        logic           out_last;
        logic           out_user;
    } parse_state_t;

    parse_state_t st_d, st_q;

    logic       in_frame;
    logic       take_byte;
    logic       start_frame;
    logic       hold_flush;
    logic       hold_full;
    logic [7:0] hold_oldest;
    logic       crc_good;

    assign in_frame  = (st_q.state == ST_DATA);
    assign take_byte = in_frame & rx_dv;

    eth_rx_crc32 u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_frame),
        .advance_i (take_byte),
        .byte_i    (rx_data),
        .good_o    (crc_good)
    );

    eth_rx_fcs_hold #(
        .W     (8),
        .DEPTH (HOLD_DEPTH)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_i  (hold_flush),
        .push_i   (take_byte),
        .byte_i   (rx_data),
        .full_o   (hold_full),
        .oldest_o (hold_oldest)
    );

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        st_d.out_last  = 1'b0;
        st_d.out_user  = 1'b0;
        start_frame    = 1'b0;
        hold_flush     = 1'b0;

        unique case (st_q.state)
            ST_HUNT: begin
                if (!rx_dv) begin
                    st_d.pre_cnt = '0;
                end else if (rx_er) begin
                    st_d.pre_cnt = '0;
                    st_d.state   = ST_DROP;
                end else if (rx_data == PRE_BYTE) begin
                    if (st_q.pre_cnt != PRE_MAX) begin
                        st_d.pre_cnt = st_q.pre_cnt + 1'b1;
                    end
                end else if (rx_data == SFD_BYTE) begin
                    st_d.pre_cnt = '0;
                    if (st_q.pre_cnt == PRE_MAX) begin
                        st_d.state   = ST_DATA;
                        st_d.len_cnt = '0;
                        st_d.err     = 1'b0;
                        start_frame  = 1'b1;
                        hold_flush   = 1'b1;
                    end else begin
                        st_d.state = ST_DROP;
                    end
                end else begin
                    st_d.pre_cnt = '0;
                end
            end

            ST_DATA: begin
                if (rx_dv) begin
                    if (hold_full) begin
                        st_d.out_valid = 1'b1;
                        st_d.out_data  = hold_oldest;
                    end
                    if (st_q.len_cnt != LEN_MAX) begin
                        st_d.len_cnt = st_q.len_cnt + 1'b1;
                    end
                    if (rx_er) begin
                        st_d.err = 1'b1;
                    end
                end else begin
                    if (hold_full) begin
                        st_d.out_valid = 1'b1;
                        st_d.out_data  = hold_oldest;
                        st_d.out_last  = 1'b1;
                        st_d.out_user  = st_q.err | ~crc_good | (st_q.len_cnt < LEN_MAX);
                    end
                    hold_flush   = 1'b1;
                    st_d.pre_cnt = '0;
                    st_d.state   = ST_HUNT;
                end
            end

            ST_DROP: begin
                if (!rx_dv) begin
                    st_d.state = ST_HUNT;
                end
            end

            default: begin
                st_d.state = ST_HUNT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_HUNT;
        end else begin
            st_q <= st_d;
        end
    end

    assign m_tdata  = st_q.out_data;
    assign m_tvalid = st_q.out_valid;
    assign m_tlast  = st_q.out_last;
    assign m_tuser  = st_q.out_user;

endmodule

// File: rtl/eth_rx_parser_chk.sv
module eth_rx_parser_chk
    import eth_rx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rx_dv,
    input logic [7:0] rx_data,
    input logic       in_frame,
    input logic       m_tvalid,
    input logic       m_tlast,
    input logic       m_tuser
);

    // R2: a frame is entered only right after a delimiter byte with data-valid high
    a_r2_entry_after_sfd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> ($past(rx_data) == SFD_BYTE) && $past(rx_dv));

    // R3: beats come only out of an active frame
    a_r3_beat_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> $past(in_frame));

    // R4: tlast only on a valid beat
    a_r4_last_is_beat: assert property (@(posedge clk) disable iff (!rst_n)
        m_tlast |-> m_tvalid);

    // R4: after the last beat the frame is closed and the next cycle is idle
    a_r4_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        m_tlast |-> !in_frame ##1 !m_tvalid);

    // R5: status only on the final beat
    a_r5_user_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        m_tuser |-> m_tlast);

    // R9: a mid-frame beat needs a byte taken in the cycle before
    a_r9_mid_beat_needs_dv: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tlast) |-> $past(rx_dv));

endmodule

bind eth_rx_parser eth_rx_parser_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_dv    (rx_dv),
    .rx_data  (rx_data),
    .in_frame (in_frame),
    .m_tvalid (m_tvalid),
    .m_tlast  (m_tlast),
    .m_tuser  (m_tuser)
);

// File: tb/eth_rx_parser_bench.sv
`timescale 1ns/1ps
module eth_rx_parser_bench;

    typedef logic [7:0] byte_q_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_dv = 1'b0;
    logic       rx_er = 1'b0;
    logic [7:0] m_tdata;
    logic       m_tvalid, m_tlast, m_tuser;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state
    int      m_mode = 0;     // 0 hunting, 1 in frame, 2 dropping
    int      m_pre = 0;
    byte_q_t m_hold;
    byte_q_t m_all;
    bit      m_err = 0;
    logic       exp_v = 0, exp_l = 0, exp_u = 0;
    logic [7:0] exp_d = 0;
    byte_q_t pl;

    always #4 clk = ~clk;

    eth_rx_parser u_eth_rx_parser (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_dv(rx_dv), .rx_er(rx_er),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tuser(m_tuser)
    );

    function automatic logic [31:0] crc_of(input byte_q_t b);
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (b[i]) begin
            c ^= {24'd0, b[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return c;
    endfunction

    function automatic void model_step(input logic dv, input logic er, input logic [7:0] d);
        exp_v = 0; exp_l = 0; exp_u = 0;
        case (m_mode)
            0: begin
                if (!dv) m_pre = 0;
                else if (er) begin m_pre = 0; m_mode = 2; end
                else if (d == 8'h55) begin if (m_pre < 7) m_pre++; end
                else if (d == 8'hD5) begin
                    if (m_pre >= 7) begin
                        m_mode = 1; m_err = 0; m_hold.delete(); m_all.delete();
                    end else m_mode = 2;
                    m_pre = 0;
                end else m_pre = 0;
            end
            1: begin
                if (dv) begin
                    m_all.push_back(d);
                    if (m_hold.size() == 5) begin exp_v = 1; exp_d = m_hold.pop_front(); end
                    m_hold.push_back(d);
                    if (er) m_err = 1;
                end else begin
                    if (m_hold.size() == 5) begin
                        exp_v = 1; exp_l = 1; exp_d = m_hold[0];
                        exp_u = m_err || (m_all.size() < 64) || (crc_of(m_all) != 32'hDEBB20E3);
                    end
                    m_hold.delete(); m_pre = 0; m_mode = 0;
                end
            end
            default: if (!dv) m_mode = 0;
        endcase
    endfunction

    task automatic compare();
        vectors++;
        if (m_tvalid !== exp_v || m_tlast !== exp_l || m_tuser !== exp_u ||
            (exp_v && m_tdata !== exp_d)) begin
            miscompares++;
            $display("FAIL %s t=%0t actual v=%b l=%b u=%b d=%h expected v=%b l=%b u=%b d=%h",
                     cur_req, $time, m_tvalid, m_tlast, m_tuser, m_tdata, exp_v, exp_l, exp_u, exp_d);
        end
    endtask

    task automatic cyc(input logic dv, input logic er, input logic [7:0] d);
        @(negedge clk);
        compare();
        rx_dv = dv; rx_er = er; rx_data = d;
        model_step(dv, er, d);
    endtask

    task automatic send_frame(input int pre_len, input int plen, input int seed, input bit corrupt,
                              input int er_at, input bit pre_er, input int gap, input string tag);
        logic [31:0] fcs;
        cur_req = tag;
        pl.delete();
        for (int i = 0; i < plen; i++) pl.push_back(8'((i * 7 + seed) & 255));
        fcs = ~crc_of(pl);
        for (int i = 0; i < 4; i++) pl.push_back(fcs[8*i +: 8]);
        if (corrupt) pl[0] = pl[0] ^ 8'h01;
        for (int i = 0; i < pre_len; i++) cyc(1'b1, pre_er && (i == 2), 8'h55);
        cyc(1'b1, 1'b0, 8'hD5);
        foreach (pl[i]) cyc(1'b1, i == er_at, pl[i]);
        for (int i = 0; i < gap; i++) cyc(1'b0, 1'b0, 8'h00);
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) begin @(negedge clk); compare(); end
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 8'h00);
        cyc(1'b0, 1'b0, 8'h00);

        send_frame(7, 60, 3, 0, -1, 0, 4, "R3");         // minimum good frame, R4 checksum held back
        send_frame(10, 100, 11, 0, -1, 0, 4, "R2");      // long preamble accepted
        send_frame(7, 80, 5, 1, -1, 0, 4, "R5");         // corrupted checksum
        send_frame(7, 20, 9, 0, -1, 0, 4, "R7");         // runt with good checksum
        send_frame(7, 59, 1, 0, -1, 0, 4, "R7");         // 63 bytes: runt boundary
        send_frame(7, 70, 2, 0, 30, 0, 4, "R6");         // receive error mid-frame
        send_frame(6, 70, 4, 0, -1, 0, 4, "R2");         // short preamble ignored
        send_frame(7, 0, 6, 0, -1, 0, 4, "R8");          // four bytes: no beats
        send_frame(7, 1, 6, 0, -1, 0, 4, "R8");          // five bytes: single tlast beat
        send_frame(7, 70, 8, 0, -1, 1, 4, "R10");        // error inside preamble
        send_frame(7, 64, 12, 0, -1, 0, 1, "R9");        // back-to-back frames
        send_frame(7, 64, 13, 0, -1, 0, 1, "R9");
        send_frame(8, 61, 14, 1, 40, 0, 3, "R9");
        cur_req = "R2";                                   // junk then valid preamble in one burst
        cyc(1'b1, 1'b0, 8'hA3); cyc(1'b1, 1'b0, 8'h55); cyc(1'b1, 1'b0, 8'h12);
        send_frame(7, 66, 21, 0, -1, 0, 4, "R2");
        cur_req = "R4";
        repeat (4) cyc(1'b0, 1'b0, 8'h00);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog %s actual=running expected=finished", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule